// File: doc/BRIEF.md
# GPIO Controller with Level and Edge Interrupts

This block is a register-mapped general-purpose I/O controller for up to 32 pins (the count is a parameter). Software writes per-pin output data and output enable through a synchronous read/write port and reads back the sampled pin levels. Every pin input passes through a two-flop synchronizer before anything uses it.

Each pin has two independent interrupt sources. The level source compares the synchronized pin against a programmable active level and is not latched. The edge source latches a per-pin event bit on a programmed edge direction, and software clears that bit by writing a one to it. Both sources are gated by their own per-pin masks and then ORed into a single summary status bit. That bit passes through a top-level mask to one registered interrupt output.

Top module: `gpio_dual_irq_ctrl`

## Requirements
- R1: After reset every register reads zero, `pin_oe` and `pin_out` are zero and `irq` is low.
- R2: A write to offset 0x44 (output data) or 0x48 (output enable) appears on `pin_out` or `pin_oe` from the next clock edge. A 1 in the enable bit marks the pin as driven. Both registers read back what was written.
- R3: Offset 0x40 returns the pins after two synchronizer flops, whatever the enable setting. Writes to 0x40 are ignored.
- R4: Level pending for pin i is (input_i XOR levelpol_i) AND levelmask_i, with level polarity at 0x50 and level mask at 0x54. A polarity bit of 1 means active-low. The level path is not latched, so it clears as soon as the pin leaves its active level.
- R5: Event bit i at offset 0x58 is set on a rising edge of the synchronized pin when edge polarity bit i (offset 0x64) is 0, and on a falling edge when it is 1. It is set whether or not its mask bit is set.
- R6: Writing 1 to a bit at 0x58 clears that event bit, and writing 0 leaves it unchanged. A qualifying edge in the same cycle as the clear keeps the bit set.
- R7: Edge pending for pin i is event_i AND eventmask_i, with the event mask at 0x5C.
- R8: Bit 0 of the summary status register (0x00) is 1 when any pin has level or edge pending, and its other bits read 0. `irq` equals that bit ANDed with bit 0 of the summary mask (0x04), registered one cycle later.
- R9: Reads of unmapped offsets return zero. Writes to the summary status register are ignored.
- R10: Read data appears on `reg_rdata` in the cycle after `reg_rd_en` is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 8 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| pin_in | input | NUM_PINS | Asynchronous pin inputs |
| pin_out | output | NUM_PINS | Output data toward the pads |
| pin_oe | output | NUM_PINS | Per-pin output enable |
| irq | output | 1 | Masked summary interrupt |

## Verification
The bench targets the race between a new edge and a write-one-to-clear in the same cycle. A design that gave the clear priority would lose the second event and read back zero. The bench also checks that events latch while their mask bit is off. A design that gated the latch with the mask would show an empty event register once the mask is opened. It flips the level polarity on a live pin and then moves the pin off its active level. A design that latched the level path would keep the status bit high after the pin had moved. Finally, it writes to the read-only input and status offsets and reads unmapped offsets. A loose address decode would corrupt state or return stale data.

// File: rtl/gdi_pkg.sv
package gdi_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam logic [ADDR_W-1:0] OFS_STATUS = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_SMASK  = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_DIN    = 8'h40;
  localparam logic [ADDR_W-1:0] OFS_DOUT   = 8'h44;
  localparam logic [ADDR_W-1:0] OFS_OE     = 8'h48;
  localparam logic [ADDR_W-1:0] OFS_LPOL   = 8'h50;
  localparam logic [ADDR_W-1:0] OFS_LMASK  = 8'h54;
  localparam logic [ADDR_W-1:0] OFS_EVENT  = 8'h58;
  localparam logic [ADDR_W-1:0] OFS_EMASK  = 8'h5C;
  localparam logic [ADDR_W-1:0] OFS_EPOL   = 8'h64;
endpackage

// File: rtl/gdi_sync.sv
module gdi_sync #(
  parameter int W = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] cur,
  output logic [W-1:0] prev
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= async_in;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= '0;
      else     chain[s] <= chain[s-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) prev <= '0;
    else     prev <= chain[STAGES-1];
  end

  assign cur = chain[STAGES-1];
endmodule

// File: rtl/gdi_edge_unit.sv
module gdi_edge_unit #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] cur,
  input  logic [W-1:0] prev,
  input  logic [W-1:0] fall_sel,
  input  logic [W-1:0] clr,
  output logic [W-1:0] hit,
  output logic [W-1:0] ev
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    assign hit[i] = fall_sel[i] ? (prev[i] & ~cur[i]) : (cur[i] & ~prev[i]);
    always_ff @(posedge clk) begin
      if (rst) ev[i] <= 1'b0;
      else     ev[i] <= hit[i] | (ev[i] & ~clr[i]);
    end
  end
endmodule

// File: rtl/gdi_cfg_regs.sv
module gdi_cfg_regs
  import gdi_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [W-1:0]      dout,
  output logic [W-1:0]      oe,
  output logic [W-1:0]      lpol,
  output logic [W-1:0]      lmask,
  output logic [W-1:0]      emask,
  output logic [W-1:0]      epol,
  output logic              smask,
  output logic [W-1:0]      ev_clr
);
  logic [W-1:0] wd;
  assign wd     = wdata[W-1:0];
  assign ev_clr = (wr_en && addr == OFS_EVENT) ? wd : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      dout  <= '0;
      oe    <= '0;
      lpol  <= '0;
      lmask <= '0;
      emask <= '0;
      epol  <= '0;
      smask <= 1'b0;
    end else if (wr_en) begin
      case (addr)
        OFS_DOUT:  dout  <= wd;
        OFS_OE:    oe    <= wd;
        OFS_LPOL:  lpol  <= wd;
        OFS_LMASK: lmask <= wd;
        OFS_EMASK: emask <= wd;
        OFS_EPOL:  epol  <= wd;
        OFS_SMASK: smask <= wdata[0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/gpio_dual_irq_ctrl.sv
module gpio_dual_irq_ctrl
  import gdi_pkg::*;
#(
  parameter int NUM_PINS = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                reg_wr_en,
  input  logic                reg_rd_en,
  input  logic [7:0]          reg_addr,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic                irq
);
  logic [NUM_PINS-1:0] sync_cur, sync_prev, edge_hit, ev, ev_clr;
  logic [NUM_PINS-1:0] lpol, lmask, emask, epol;
  logic                smask, status_bit;
  logic [NUM_PINS-1:0] lvl_pend, edg_pend;
  logic [DATA_W-1:0]   rd_mux;

  gdi_sync #(.W(NUM_PINS), .STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .async_in(pin_in), .cur(sync_cur), .prev(sync_prev)
  );

  gdi_cfg_regs #(.W(NUM_PINS)) u_cfg (
    .clk(clk), .rst(rst), .wr_en(reg_wr_en), .addr(reg_addr), .wdata(reg_wdata),
    .dout(pin_out), .oe(pin_oe), .lpol(lpol), .lmask(lmask), .emask(emask),
    .epol(epol), .smask(smask), .ev_clr(ev_clr)
  );

  gdi_edge_unit #(.W(NUM_PINS)) u_edge (
    .clk(clk), .rst(rst), .cur(sync_cur), .prev(sync_prev), .fall_sel(epol),
    .clr(ev_clr), .hit(edge_hit), .ev(ev)
  );

  assign lvl_pend   = (sync_cur ^ lpol) & lmask;
  assign edg_pend   = ev & emask;
  assign status_bit = |{lvl_pend, edg_pend};

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= status_bit & smask;
  end

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      OFS_STATUS: rd_mux[0] = status_bit;
      OFS_SMASK:  rd_mux[0] = smask;
      OFS_DIN:    rd_mux    = DATA_W'(sync_cur);
      OFS_DOUT:   rd_mux    = DATA_W'(pin_out);
      OFS_OE:     rd_mux    = DATA_W'(pin_oe);
      OFS_LPOL:   rd_mux    = DATA_W'(lpol);
      OFS_LMASK:  rd_mux    = DATA_W'(lmask);
      OFS_EVENT:  rd_mux    = DATA_W'(ev);
      OFS_EMASK:  rd_mux    = DATA_W'(emask);
      OFS_EPOL:   rd_mux    = DATA_W'(epol);
      default:    rd_mux    = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)            reg_rdata <= '0;
    else if (reg_rd_en) reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/gdi_checker.sv
module gdi_checker #(
  parameter int N = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         wr_en,
  input logic [7:0]   addr,
  input logic [31:0]  wdata,
  input logic [N-1:0] oe,
  input logic         irq,
  input logic         status_bit,
  input logic         smask,
  input logic [N-1:0] ev,
  input logic [N-1:0] hit
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) $past(rst) |-> (irq == 1'b0 && oe == '0));

  // R2
  oe_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 8'h48) |=> oe == $past(wdata[N-1:0]));

  // R3
  din_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 8'h40) |=> $stable(oe));

  // R5
  ev_rise_needs_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (|(ev & ~$past(ev))) |-> ((ev & ~$past(ev) & ~$past(hit)) == '0));

  // R8
  irq_source_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> ($past(status_bit) && $past(smask)));
endmodule

bind gpio_dual_irq_ctrl gdi_checker #(.N(NUM_PINS)) u_chk (
  .clk(clk), .rst(rst), .wr_en(reg_wr_en), .addr(reg_addr), .wdata(reg_wdata),
  .oe(pin_oe), .irq(irq), .status_bit(status_bit), .smask(smask),
  .ev(ev), .hit(edge_hit)
);

// File: tb/gpio_dual_irq_ctrl_test.sv
`timescale 1ns/1ps
module gpio_dual_irq_ctrl_test;
  localparam int N = 16;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [N-1:0] pin_in = '0;
  logic [N-1:0] pin_out, pin_oe;
  logic irq;

  int checks = 0;
  int fails = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];
  logic rd_seen = 1'b0;

  always #4 clk = ~clk;

  gpio_dual_irq_ctrl #(.NUM_PINS(N)) uut (
    .clk(clk), .rst(rst), .reg_wr_en(wr_en), .reg_rd_en(rd_en), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .irq(irq)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: R10 read data is compared the cycle after the strobe
  always @(posedge clk) rd_seen <= rd_en;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) chk("R10 unexpected read", rdata, 32'h0);
      else chk(tag_q.pop_front(), rdata, exp_q.pop_front());
    end
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
    @(negedge clk); rd_en = 1'b1; addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(posedge clk); @(negedge clk); rd_en = 1'b0;
    @(posedge clk);
  endtask

  task automatic pins(logic [N-1:0] v);
    @(negedge clk); pin_in = v;
    repeat (4) @(posedge clk);
  endtask

  task automatic settle();
    repeat (2) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R1 reset state
    chk("R1 pin_oe", 32'(pin_oe), 0);
    chk("R1 pin_out", 32'(pin_out), 0);
    chk("R1 irq", 32'(irq), 0);
    rd(8'h48, 0, "R1 oe reg");
    rd(8'h58, 0, "R1 event reg");
    rd(8'h00, 0, "R1 status");
    // R2 outputs
    wr(8'h44, 32'hA5A5);
    wr(8'h48, 32'h00FF);
    chk("R2 pin_out", 32'(pin_out), 32'hA5A5);
    chk("R2 pin_oe", 32'(pin_oe), 32'h00FF);
    rd(8'h44, 32'hA5A5, "R2 dout readback");
    rd(8'h48, 32'h00FF, "R2 oe readback");
    // R3 input sampling, independent of direction
    pins(16'h1234);
    rd(8'h40, 32'h1234, "R3 din");
    wr(8'h40, 32'hFFFF);
    rd(8'h40, 32'h1234, "R3 din write ignored");
    // R9 status write ignored, unmapped reads zero
    wr(8'h00, 32'h1);
    rd(8'h00, 0, "R9 status write ignored");
    rd(8'h10, 0, "R9 unmapped 0x10");
    rd(8'h60, 0, "R9 unmapped 0x60");
    // R4 level path
    wr(8'h54, 32'h0008);
    rd(8'h00, 0, "R4 inactive level");
    pins(16'h123C);
    rd(8'h00, 1, "R4 active high pending");
    chk("R8 irq masked off", 32'(irq), 0);
    wr(8'h04, 1);
    settle();
    chk("R8 irq asserted", 32'(irq), 1);
    wr(8'h50, 32'h0008);
    settle();
    chk("R4 active low inverts", 32'(irq), 0);
    pins(16'h1234);
    rd(8'h00, 1, "R4 active low pending");
    pins(16'h123C);
    rd(8'h00, 0, "R4 not latched");
    wr(8'h54, 0);
    // R5 edges latched without mask: rises from reset plus bit3 twice
    rd(8'h58, 32'h123C, "R5 latched unmasked");
    wr(8'h58, 0);
    rd(8'h58, 32'h123C, "R6 write zero keeps");
    wr(8'h58, 32'hFFFF);
    rd(8'h58, 0, "R6 write one clears");
    // R5/R7 falling edge selection
    wr(8'h64, 32'h0080);
    wr(8'h5C, 32'h0080);
    pins(16'h12BC);
    rd(8'h58, 0, "R5 rising ignored when falling selected");
    pins(16'h123C);
    rd(8'h58, 32'h0080, "R5 falling latched");
    rd(8'h00, 1, "R7 edge pending");
    chk("R8 irq from edge", 32'(irq), 1);
    wr(8'h58, 32'h0080);
    settle();
    chk("R6 irq drops after clear", 32'(irq), 0);
    // R6 same-cycle edge and clear
    pins(16'h123E);
    rd(8'h58, 32'h0002, "R5 rising bit1");
    pins(16'h123C);
    @(negedge clk); pin_in = 16'h123E;
    @(posedge clk); @(posedge clk);
    @(negedge clk); wr_en = 1'b1; addr = 8'h58; wdata = 32'h2;
    @(posedge clk); @(negedge clk); wr_en = 1'b0;
    rd(8'h58, 32'h0002, "R6 edge wins over clear");
    wr(8'h58, 32'h2);
    rd(8'h58, 0, "R6 clear");
    // R1 reset mid-run
    @(negedge clk); rst = 1'b1;
    @(posedge clk); @(negedge clk); rst = 1'b0;
    chk("R1 oe after reset", 32'(pin_oe), 0);
    rd(8'h04, 0, "R1 smask after reset");
    settle();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule